// File: doc/BRIEF.md
# Card Bus Strobe Timing Sequencer

This block drives one 16-bit card access at a time on a bus timed by the host clock. A requester presents an address, write data, a read/write flag and a memory/I/O flag. When the sequencer is idle it accepts the request. It then produces the address-drive enable, the card enable and one of four strobes: memory read, memory write, I/O read or I/O write. At the end it returns the read data and a one-clock done pulse.

Each access moves through four phases in a fixed order: address setup, strobe setup, strobe active and strobe hold. The length of each phase comes from one of two 32-bit timing words. One word serves memory space and the other serves I/O space, and both use the same layout. The sequencer copies the selected word when it accepts the request. Changing either word during an access therefore has no effect on that access.

Memory writes and I/O writes use different data-drive windows. An I/O write drives data from the moment the card enable falls. A memory write waits for the strobe.

Top module: `card_strobe_seq`

## Requirements
- R1: After reset, and whenever idle: `ce_n`, `oe_n`, `we_n`, `iord_n` and `iowr_n` are 1; `addr_oe`, `data_oe` and `done` are 0; `req_ready` is 1.
- R2: The timing word layout is: address setup in bits 3:0, strobe setup in bits 11:8, strobe active length in bits 21:16, strobe hold in bits 27:24. A field value N gives N clocks for its phase, and 0 skips the phase. The strobe active phase is the exception: 0 gives one clock. The phases run in the order address setup, strobe setup, strobe active, strobe hold, starting in the clock after the accepting edge.
- R3: `addr_oe` is 1 from the first address-setup clock through the last strobe-hold clock. During that time `card_addr` equals the accepted request address.
- R4: `ce_n` is 0 exactly during the strobe-setup, strobe-active and strobe-hold phases.
- R5: During the strobe-active phase exactly one strobe is 0. It is `oe_n` for a memory read (`req_io`=0, `req_write`=0), `we_n` for a memory write, `iord_n` for an I/O read and `iowr_n` for an I/O write. All strobes are 1 in every other phase.
- R6: For a memory write, `data_oe` is 1 exactly during the strobe-active and strobe-hold phases, with `data_out` equal to the request write data.
- R7: For an I/O write, `data_oe` is 1 exactly during the strobe-setup, strobe-active and strobe-hold phases, with `data_out` equal to the request write data. For reads, `data_oe` stays 0.
- R8: For a read, `rd_data` takes the value `data_in` had in the last strobe-active clock. That value is presented while `done` is 1.
- R9: `done` is 1 for exactly one clock, the clock after the last strobe-hold clock. `req_ready` is 1 only when idle. A request presented while busy is ignored.
- R10: `req_io`=0 selects `mem_timing` and `req_io`=1 selects `io_timing`. The word is captured at acceptance, so changing either word during an access does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| mem_timing | input | 32 | Phase lengths for memory accesses |
| io_timing | input | 32 | Phase lengths for I/O accesses |
| data_in | input | DW | Data returned by the card |
| req_ready | output | 1 | Idle, request will be accepted |
| card_addr | output | AW | Address to the card |
| addr_oe | output | 1 | Address drive enable |
| ce_n | output | 1 | Card enable, active low |
| oe_n | output | 1 | Memory read strobe, active low |
| we_n | output | 1 | Memory write strobe, active low |
| iord_n | output | 1 | I/O read strobe, active low |
| iowr_n | output | 1 | I/O write strobe, active low |
| data_out | output | DW | Write data to the card |
| data_oe | output | 1 | Write data drive enable |
| rd_data | output | DW | Captured read data |
| done | output | 1 | One-clock access completion pulse |

## Verification
The bench runs every combination of field values 0 to 2 for all four phases and all four access kinds. It compares each output in every clock against a phase position computed from the field values. This catches a sequencer that lets a zero field cost a clock, allows a zero-length strobe, or swaps the memory and I/O write-data windows. The card data changes every clock, so capturing one edge early or late returns the wrong word. During each access the bench also holds a competing request with a different address and changes both timing words. A design that accepted requests while busy, or read its timing live, would then shift its address or its phase boundaries.

// File: rtl/card_strobe_seq.sv
module card_strobe_seq #(
  parameter int AW = 26,
  parameter int DW = 16,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_io,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [31:0]   mem_timing,
  input  logic [31:0]   io_timing,
  input  logic [DW-1:0] data_in,
  output logic          req_ready,
  output logic [AW-1:0] card_addr,
  output logic          addr_oe,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          iord_n,
  output logic          iowr_n,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic [DW-1:0] rd_data,
  output logic          done
);
  localparam int AS_LO = 0,  AS_W = 4;
  localparam int SS_LO = 8,  SS_W = 4;
  localparam int SL_LO = 16, SL_W = 6;
  localparam int SH_LO = 24, SH_W = 4;

  typedef enum logic [2:0] {IDLE, ADS, STS, STB, STH, FIN} phase_t;
  phase_t st;

  logic [CW-1:0] cnt;
  logic [SS_W-1:0] t_ss;
  logic [SL_W-1:0] t_sl;
  logic [SH_W-1:0] t_sh;
  logic wr, io;

  wire [31:0]     tsel = req_io ? io_timing : mem_timing;
  wire [AS_W-1:0] n_as = tsel[AS_LO +: AS_W];
  wire [SS_W-1:0] n_ss = tsel[SS_LO +: SS_W];
  wire [SL_W-1:0] n_sl = tsel[SL_LO +: SL_W];
  wire [CW-1:0]   sl_last = (t_sl == '0) ? '0 : CW'(t_sl - 1'b1);
  wire            last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; t_ss <= '0; t_sl <= '0; t_sh <= '0;
      wr <= 1'b0; io <= 1'b0; card_addr <= '0; data_out <= '0; rd_data <= '0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          t_ss <= n_ss; t_sl <= n_sl; t_sh <= tsel[SH_LO +: SH_W];
          wr <= req_write; io <= req_io;
          card_addr <= req_addr; data_out <= req_wdata;
          if (n_as != '0) begin
            st <= ADS; cnt <= CW'(n_as - 1'b1);
          end else if (n_ss != '0) begin
            st <= STS; cnt <= CW'(n_ss - 1'b1);
          end else begin
            st <= STB; cnt <= (n_sl == '0) ? '0 : CW'(n_sl - 1'b1);
          end
        end
        ADS: if (!last) cnt <= cnt - 1'b1;
             else if (t_ss != '0) begin st <= STS; cnt <= CW'(t_ss - 1'b1); end
             else begin st <= STB; cnt <= sl_last; end
        STS: if (!last) cnt <= cnt - 1'b1;
             else begin st <= STB; cnt <= sl_last; end
        STB: if (!last) cnt <= cnt - 1'b1;
             else begin
               if (!wr) rd_data <= data_in;
               if (t_sh != '0) begin st <= STH; cnt <= CW'(t_sh - 1'b1); end
               else st <= FIN;
             end
        STH: if (!last) cnt <= cnt - 1'b1;
             else st <= FIN;
        default: st <= IDLE;
      endcase
    end
  end

  wire strobing = (st == STB);
  assign req_ready = (st == IDLE);
  assign done      = (st == FIN);
  assign addr_oe   = (st == ADS) || (st == STS) || (st == STB) || (st == STH);
  assign ce_n      = !((st == STS) || (st == STB) || (st == STH));
  assign oe_n      = !(strobing && !io && !wr);
  assign we_n      = !(strobing && !io &&  wr);
  assign iord_n    = !(strobing &&  io && !wr);
  assign iowr_n    = !(strobing &&  io &&  wr);
  assign data_oe   = wr && ((st == STB) || (st == STH) || (io && st == STS));
endmodule

module card_strobe_seq_chk #(
  parameter int AW = 26,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic [AW-1:0] card_addr,
  input logic          addr_oe,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          iord_n,
  input logic          iowr_n,
  input logic          data_oe,
  input logic [DW-1:0] rd_data,
  input logic          done
);
  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~oe_n, ~we_n, ~iord_n, ~iowr_n}));
  // R4
  strobe_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(oe_n && we_n && iord_n && iowr_n) |-> !ce_n);
  // R3
  addr_with_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> addr_oe);
  // R7
  data_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !ce_n);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(card_addr));
  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(rd_data));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ce_n && !addr_oe && !data_oe && !done);
endmodule

bind card_strobe_seq card_strobe_seq_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_card_strobe_seq.sv
`timescale 1ns/1ps
module sim_card_strobe_seq;
  localparam int AW = 26, DW = 16;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_io = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, data_in = '0;
  logic [31:0] mem_timing = '0, io_timing = '0;
  logic req_ready, addr_oe, ce_n, oe_n, we_n, iord_n, iowr_n, data_oe, done;
  logic [AW-1:0] card_addr;
  logic [DW-1:0] data_out, rd_data;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  card_strobe_seq u0 (.*);

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] tword(int a, int s, int l, int h);
    return (32'(h) << 24) | (32'(l) << 16) | (32'(s) << 8) | 32'(a);
  endfunction

  task automatic access(input int a, input int s, input int l, input int h,
                        input bit io, input bit wr, input int idx);
    int L, tot, ph;
    logic [AW-1:0] ad;
    logic [DW-1:0] wd, cap;
    logic [3:0] sexp;
    bit bad_a, bad_ce, bad_st, bad_d, bad_r;
    L = (l == 0) ? 1 : l;
    tot = a + s + L + h;
    ad = AW'(32'h0100_0000 + idx * 7);
    wd = DW'(16'h5A00 + idx);
    // R10: the unused word gets a misleading value
    if (io) begin io_timing = tword(a, s, l, h); mem_timing = tword(3, 3, 3, 3); end
    else    begin mem_timing = tword(a, s, l, h); io_timing = tword(3, 3, 3, 3); end
    @(negedge clk);
    chk(req_ready, "R9 ready before access", 32'(req_ready), 1);
    req_valid = 1; req_write = wr; req_io = io; req_addr = ad; req_wdata = wd;
    @(negedge clk);
    // R9/R10: competing request and timing changes while busy
    req_addr = ~ad; req_wdata = ~wd; req_write = ~wr; req_io = ~io;
    mem_timing = tword(1, 4, 5, 3); io_timing = tword(2, 1, 6, 1);
    bad_a = 0; bad_ce = 0; bad_st = 0; bad_d = 0; bad_r = 0; cap = '0;
    for (int c = 0; c <= tot; c++) begin
      ph = (c < a) ? 0 : (c < a + s) ? 1 : (c < a + s + L) ? 2 : (c < tot) ? 3 : 4;
      if ((addr_oe !== (ph < 4)) || (ph < 4 && card_addr !== ad)) bad_a = 1;
      if (ce_n !== !(ph >= 1 && ph <= 3)) bad_ce = 1;
      sexp = 4'b1111;
      if (ph == 2) sexp[{io, wr}] = 1'b0;
      if ({iowr_n, iord_n, we_n, oe_n} !== sexp) bad_st = 1;
      if (data_oe !== (wr && (ph == 2 || ph == 3 || (io && ph == 1)))) bad_d = 1;
      if (data_oe && data_out !== wd) bad_d = 1;
      if (done !== (ph == 4) || req_ready !== 1'b0) bad_r = 1;
      data_in = DW'({idx[7:0], c[7:0]});
      if (c == a + s + L - 1) cap = data_in;
      if (c == tot) req_valid = 0;
      @(negedge clk);
    end
    chk(!bad_a, $sformatf("R3 addr window a%0d s%0d l%0d h%0d", a, s, l, h), 32'(bad_a), 0);
    chk(!bad_ce, $sformatf("R4 ce window a%0d s%0d l%0d h%0d", a, s, l, h), 32'(bad_ce), 0);
    chk(!bad_st, $sformatf("R5 R2 strobe io%0d wr%0d l%0d", io, wr, l), 32'(bad_st), 0);
    chk(!bad_d, $sformatf("%s data window s%0d", io ? "R7" : "R6", s), 32'(bad_d), 0);
    chk(!bad_r, "R9 R10 done timing", 32'(bad_r), 0);
    chk(req_ready && ce_n && !done, "R1 back to idle", 32'(req_ready), 1);
    if (!wr) chk(rd_data === cap, "R8 read capture", 32'(rd_data), 32'(cap));
  endtask

  initial begin
    int idx;
    fork
      begin
        repeat (3) @(negedge clk);
        // R1
        chk(req_ready && ce_n && oe_n && we_n && iord_n && iowr_n && !addr_oe && !data_oe && !done,
            "R1 reset state", {ce_n, oe_n, we_n, iord_n, iowr_n, addr_oe, data_oe, done}, 8'hF8);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && ce_n && !done, "R1 idle after reset", 32'(req_ready), 1);
        idx = 0;
        for (int k = 0; k < 4; k++)
          for (int a = 0; a < 3; a++)
            for (int s = 0; s < 3; s++)
              for (int l = 0; l < 3; l++)
                for (int h = 0; h < 3; h++) begin
                  access(a, s, l, h, k[1], k[0], idx);
                  idx++;
                end
        // R2 longest fields
        access(15, 15, 63, 15, 1'b1, 1'b1, idx);
        access(15, 0, 63, 15, 1'b0, 1'b0, idx + 1);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule